// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block is the digital controller that brings a two-output supply up in a controlled way and takes it down on a fault. It receives four digital flags from analog comparators: supply-good, which already has hysteresis applied; one undervoltage flag per output; and an inhibit flag. Each flag passes through a two-flop synchroniser. The block drives a shared reference code that ramps from zero to full scale, one enable for each output driver, and two status bits.

When supply-good is high and inhibit is low, both enables go high together and the reference code climbs by one step per timer tick until it reaches full scale. An undervoltage flag from either output is ignored while the code is below a programmable unmask point. Once the code reaches that point, the flag turns both outputs off in the same cycle. The block then waits for a fixed number of internal ramp periods with the outputs held off, which is the hiccup delay. After that it starts a new real ramp. This retry repeats with no limit for as long as the fault persists. Inhibit holds both outputs off, and releasing it starts a fresh ramp. Loss of supply-good returns the block to its reset state.

All intervals are counted in ticks of a parameterised clock divider. With `TICK_DIV` chosen so that `(2**CODE_W-1)*TICK_DIV` clock periods equal about 3.4 ms, and `UV_UNMASK_CODE` at about a quarter of full scale, the timing falls in the usual range: a ramp of about 3.4 ms, unmasking about 0.9 ms into the ramp, and three dummy ramp periods as the retry delay.

Top module: `softstart_hiccup_seq`

## Requirements
- R1: After reset, and while synchronised supply-good is low, both enables, `ss_done`, `fault_latched` and `ref_code` are 0. No ramp starts until supply-good is high.
- R2: A ramp starts with both enables high and `ref_code` = 0. `ref_code` then rises by exactly 1 every `TICK_DIV` clocks and reaches `2**CODE_W-1` after `(2**CODE_W-1)*TICK_DIV` clocks, where it stays.
- R3: An undervoltage flag on either output, once acted on, drives both enables low in the same cycle and sets `ref_code` to 0.
- R4: After an undervoltage shutdown the outputs stay off for exactly `DUMMY_RAMPS*(2**CODE_W-1)*TICK_DIV` clocks. A new ramp from code 0 then follows.
- R5: During a ramp, undervoltage flags are ignored while `ref_code` < `UV_UNMASK_CODE`. A flag that is still present when the code equals `UV_UNMASK_CODE` causes shutdown on the next clock, so that code value is visible for one cycle.
- R6: While the undervoltage flag persists, the shutdown, delay and ramp sequence repeats with no limit.
- R7: While inhibit is high, both enables are low and `ref_code` is 0. Releasing inhibit starts a fresh ramp from code 0.
- R8: Loss of supply-good at any time returns all outputs to their reset values.
- R9: `ss_done` is high exactly while the ramp code is held at full scale with the outputs enabled.
- R10: `fault_latched` is high exactly for the duration of each hiccup delay, and both enables are low throughout it.
- R11: Every input reaches the outputs through two synchroniser flops and one state register. A change driven between clock edges appears on the outputs after the third following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_good | input | 1 | Bias supply good (asynchronous, hysteresis applied upstream) |
| uv_a | input | 1 | Undervoltage flag, output A (asynchronous) |
| uv_b | input | 1 | Undervoltage flag, output B (asynchronous) |
| inhibit | input | 1 | Shutdown request, held high to keep outputs off (asynchronous) |
| ref_code | output | CODE_W | Soft-start reference code shared by both outputs |
| en_a | output | 1 | Driver enable, output A |
| en_b | output | 1 | Driver enable, output B |
| ss_done | output | 1 | Ramp complete, code at full scale |
| fault_latched | output | 1 | Hiccup delay in progress |

## Verification
The assertions assume that the comparator flags are plain levels. They also assume that a flag raised during a hiccup delay has no effect of its own until the next ramp passes the unmask point. The masking property further assumes that supply-good and inhibit are stable whenever it is evaluated. To stay within these assumptions, the stimulus changes each flag only between clock edges. It holds each flag for several cycles, and it applies an undervoltage pulse only during a ramp or in the full-scale state, never while supply-good or inhibit is changing. Undervoltage pulses that are meant to be ignored are placed early enough that the synchronised copy has cleared before the code reaches the unmask point.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_INH  = 3'd1,
    ST_RAMP = 3'd2,
    ST_FULL = 3'd3,
    ST_HIC  = 3'd4
  } hs_state_e;
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta_q;
  logic [N-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/hs_tick.sv
module hs_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;
      assign tick = (div_q == LAST);
      always_ff @(posedge clk) begin
        if (rst || clr || tick) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/hs_core.sv
module hs_core
  import hs_pkg::*;
#(
  parameter int CODE_W         = 6,
  parameter int UV_UNMASK_CODE = 16,
  parameter int DUMMY_RAMPS    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              pg_s,
  input  logic              inh_s,
  input  logic              uv_s,
  output logic              restart,
  output logic [CODE_W-1:0] code_q,
  output logic              en_q,
  output logic              done_q,
  output logic              fault_q
);
  localparam int RW = $clog2(DUMMY_RAMPS) + 1;
  localparam logic [CODE_W-1:0] FULL    = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] FULL_M1 = FULL - 1'b1;
  localparam logic [CODE_W-1:0] MASK_C  = CODE_W'(UV_UNMASK_CODE);
  localparam logic [RW-1:0]     REP_END = RW'(DUMMY_RAMPS - 1);

  hs_state_e         st_q, st_d;
  logic [CODE_W-1:0] cnt_q, cnt_d;
  logic [RW-1:0]     rep_q, rep_d;
  logic              en_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    rep_d = rep_q;
    unique case (st_q)
      ST_OFF:  if (pg_s) st_d = inh_s ? ST_INH : ST_RAMP;
      ST_INH:  if (!inh_s) st_d = ST_RAMP;
      ST_RAMP: begin
        if (uv_s && cnt_q >= MASK_C) st_d = ST_HIC;
        else if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == FULL_M1) st_d = ST_FULL;
        end
      end
      ST_FULL: if (uv_s) st_d = ST_HIC;
      ST_HIC: begin
        if (tick) begin
          if (cnt_q == FULL_M1) begin
            cnt_d = '0;
            if (rep_q == REP_END) st_d = ST_RAMP;
            else                  rep_d = rep_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = ST_OFF;
    endcase
    if (st_q != ST_OFF && inh_s) st_d = ST_INH;
    if (!pg_s) st_d = ST_OFF;
    restart = (st_d != st_q);
    if (restart) begin
      cnt_d = (st_d == ST_FULL) ? FULL : '0;
      rep_d = '0;
    end
  end

  assign en_d = (st_d == ST_RAMP) || (st_d == ST_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_OFF;
      cnt_q   <= '0;
      rep_q   <= '0;
      en_q    <= 1'b0;
      code_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      rep_q   <= rep_d;
      en_q    <= en_d;
      code_q  <= en_d ? cnt_d : '0;
      done_q  <= (st_d == ST_FULL);
      fault_q <= (st_d == ST_HIC);
    end
  end

  AST_SUPPLY_LOSS_OFF: assert property (@(posedge clk) disable iff (rst)
    !pg_s |=> (!en_q && code_q == '0 && !fault_q)); // R8
  AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (rst)
    inh_s |=> !en_q); // R7
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
    (en_q && $past(en_q)) |-> (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1)); // R2
  AST_DONE_AT_FULL: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (en_q && code_q == FULL)); // R9
  AST_FAULT_OUTPUTS_OFF: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> (!en_q && !done_q && code_q == '0)); // R10
  AST_UV_MASKED: assert property (@(posedge clk) disable iff (rst)
    (en_q && !done_q && code_q < MASK_C && pg_s && !inh_s) |=> en_q); // R5
endmodule

// File: rtl/softstart_hiccup_seq.sv
module softstart_hiccup_seq #(
  parameter int CODE_W         = 6,
  parameter int TICK_DIV       = 4,
  parameter int UV_UNMASK_CODE = 16,
  parameter int DUMMY_RAMPS    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_good,
  input  logic              uv_a,
  input  logic              uv_b,
  input  logic              inhibit,
  output logic [CODE_W-1:0] ref_code,
  output logic              en_a,
  output logic              en_b,
  output logic              ss_done,
  output logic              fault_latched
);
  logic [3:0] raw_in, syn;
  logic       tick, restart, en_q;

  assign raw_in = {supply_good, inhibit, uv_b, uv_a};

  hs_sync2 #(.N(4)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn)
  );

  hs_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (restart),
    .tick (tick)
  );

  hs_core #(
    .CODE_W         (CODE_W),
    .UV_UNMASK_CODE (UV_UNMASK_CODE),
    .DUMMY_RAMPS    (DUMMY_RAMPS)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .pg_s    (syn[3]),
    .inh_s   (syn[2]),
    .uv_s    (syn[1] | syn[0]),
    .restart (restart),
    .code_q  (ref_code),
    .en_q    (en_q),
    .done_q  (ss_done),
    .fault_q (fault_latched)
  );

  assign en_a = en_q;
  assign en_b = en_q;

  AST_JOINT_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_latched) |-> ($fell(en_a) && $fell(en_b) && ref_code == '0)); // R3
endmodule

// File: tb/sim_softstart_hiccup_seq.sv
module sim_softstart_hiccup_seq;
  localparam int W     = 6;
  localparam int DIV   = 4;
  localparam int MASK  = 16;
  localparam int DUMMY = 3;
  localparam int FULL  = (1 << W) - 1;
  localparam int VW    = W + 4;

  logic clk = 1'b0, rst = 1'b1;
  logic supply_good = 1'b0, uv_a = 1'b0, uv_b = 1'b0, inhibit = 1'b0;
  logic [W-1:0] ref_code;
  logic en_a, en_b, ss_done, fault_latched;

  always #10 clk = ~clk;

  softstart_hiccup_seq #(
    .CODE_W(W), .TICK_DIV(DIV), .UV_UNMASK_CODE(MASK), .DUMMY_RAMPS(DUMMY)
  ) u0 (
    .clk(clk), .rst(rst), .supply_good(supply_good), .uv_a(uv_a), .uv_b(uv_b),
    .inhibit(inhibit), .ref_code(ref_code), .en_a(en_a), .en_b(en_b),
    .ss_done(ss_done), .fault_latched(fault_latched)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [VW-1:0] exp_q[$];
  string         req_q[$];
  logic [VW-1:0] prev_obs = '0;
  int t_en = 0, t_done = 0, t_frise = 0, t_ffall = 0, t_chg = 0;
  int n_en = 0, n_frise = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [VW-1:0] mk(bit en, bit dn, bit flt, int code);
    return {en, en, dn, flt, W'(code)};
  endfunction

  task automatic push(logic [VW-1:0] v, string req);
    exp_q.push_back(v);
    req_q.push_back(req);
  endtask

  // Ramp from code 0 up to 'upto'; ss_done expected only at full scale (R2, R9)
  task automatic push_ramp(int upto, string req);
    push(mk(1, 0, 0, 0), req);
    for (int k = 1; k <= upto; k++) push(mk(1, k == FULL, 0, k), req);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops one expected item per observed output change
  always @(negedge clk) begin
    if (!rst) begin
      logic [VW-1:0] obs;
      obs = {en_a, en_b, ss_done, fault_latched, ref_code};
      if (obs != prev_obs) begin
        t_chg = cyc;
        if (obs[VW-1] && !prev_obs[VW-1]) begin t_en = cyc; n_en++; end
        if (obs[VW-3] && !prev_obs[VW-3]) t_done = cyc;
        if (obs[VW-4] && !prev_obs[VW-4]) begin t_frise = cyc; n_frise++; end
        if (!obs[VW-4] && prev_obs[VW-4]) t_ffall = cyc;
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected output change", int'(obs), int'(prev_obs));
        end else begin
          logic [VW-1:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(obs == e, r, "output vector", int'(obs), int'(e));
        end
        prev_obs = obs;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int t_drive, base;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check({en_a, en_b, ss_done, fault_latched, ref_code} == '0, "R1", "reset outputs",
          int'({en_a, en_b, ss_done, fault_latched, ref_code}), 0);
    repeat (20) @(negedge clk);
    check(!en_a && !en_b && ref_code == 0, "R1", "held off without supply", int'(en_a), 0);

    // R2, R9, R11: first ramp
    push_ramp(FULL, "R2");
    supply_good = 1'b1;
    t_drive = cyc;
    drain();
    check(t_en - t_drive == 3, "R11", "input to output latency", t_en - t_drive, 3);
    check(t_done - t_en == FULL * DIV, "R2", "ramp duration", t_done - t_en, FULL * DIV);

    // R3, R4, R10: undervoltage on output A while at full scale
    push(mk(0, 0, 1, 0), "R3");
    push_ramp(FULL, "R4");
    uv_a = 1'b1;
    repeat (10) @(negedge clk);
    uv_a = 1'b0;
    drain();
    check(t_ffall - t_frise == DUMMY * FULL * DIV, "R4", "hiccup delay", t_ffall - t_frise,
          DUMMY * FULL * DIV);
    check(t_ffall == t_en, "R10", "fault clears as ramp starts", t_ffall, t_en);
    check(t_done - t_en == FULL * DIV, "R2", "retry ramp duration", t_done - t_en, FULL * DIV);

    // R5: early undervoltage pulse during a ramp is ignored
    push(mk(0, 0, 1, 0), "R3");
    push_ramp(FULL, "R5");
    base = n_frise;
    uv_b = 1'b1;
    repeat (6) @(negedge clk);
    uv_b = 1'b0;
    while (n_en == 0 || !en_a) @(negedge clk);
    repeat (8) @(negedge clk);
    uv_a = 1'b1;
    repeat (8) @(negedge clk);
    uv_a = 1'b0;
    drain();
    check(n_frise - base == 1, "R5", "faults from masked pulse", n_frise - base, 1);

    // R6: persistent undervoltage retries; unmask point at code MASK
    push(mk(0, 0, 1, 0), "R6");
    push_ramp(MASK, "R5");
    push(mk(0, 0, 1, 0), "R6");
    push_ramp(FULL, "R6");
    base = n_frise;
    uv_b = 1'b1;
    while (n_frise < base + 2) @(negedge clk);
    uv_b = 1'b0;
    drain();
    check(n_frise - base == 2, "R6", "hiccup repetitions", n_frise - base, 2);

    // R7: inhibit holds outputs off, release restarts
    push(mk(0, 0, 0, 0), "R7");
    inhibit = 1'b1;
    t_drive = cyc;
    drain();
    check(t_chg - t_drive == 3, "R11", "inhibit latency", t_chg - t_drive, 3);
    repeat (60) @(negedge clk);
    check(!en_a && !en_b && ref_code == 0, "R7", "off while inhibited", int'(en_a), 0);
    push_ramp(FULL, "R7");
    inhibit = 1'b0;
    drain();

    // R8: supply loss at full scale
    push(mk(0, 0, 0, 0), "R8");
    supply_good = 1'b0;
    t_drive = cyc;
    drain();
    check(t_chg - t_drive == 3, "R8", "supply loss latency", t_chg - t_drive, 3);
    repeat (20) @(negedge clk);
    check(!ss_done && !fault_latched && ref_code == 0, "R8", "reset state after loss",
          int'(ref_code), 0);
    push_ramp(FULL, "R1");
    supply_good = 1'b1;
    drain();
    check(exp_q.size() == 0, "R2", "expected items left", exp_q.size(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule